// File: doc/BRIEF.md
# Multichannel Interpolating Time Interval Digitizer

This block is the digital back end of a converter that measures, on several channels at once, the time from one shared start event to an independent stop event on each channel. A typical use is time-of-flight ranging. One start pulse marks the moment of emission, and each receiver channel reports when its echo arrives. Every interval is formed from two parts. The first is the number of whole reference clock cycles counted by a single coarse counter that all channels share. The second is a fine fraction, taken from how far the start and stop edges had travelled along a sampled multiphase delay line when the clock edge caught them.

The delay line vectors are already captured when they arrive at the block's inputs. Each one is reduced to a binary tap count. The block combines these counts with the coarse count and rescales the result by a per-channel factor. That factor comes from a calibration pass, which measures how many delay stages span one reference period. The output is therefore expressed in a fixed unit of 1/`LSB_PER_CLK` of a clock period, whatever the process or temperature. If a channel sees no stop before the coarse counter reaches its limit, it reports an overflow pulse and no value.

Top module: `tdc_backend`

## Requirements
- R1: After reset every `ts_valid` and `ts_ovf` bit is 0 and every `ts_value` field is 0.
- R2: A phase vector is reduced to the number of ones it holds, so bubbles count. For example, 8'b0101_1011 counts as 5 and 8'b0000_1101 as 3.
- R3: A result equals ((N·P + Fs − Fp) · floor(LSB_PER_CLK·4096 / P)) >> 12, truncated to OUT_W bits. N is the number of rising clock edges from the start capture edge to the stop capture edge. P is the channel's calibrated period, Fs is the start count and Fp is the stop count. Channel i occupies bits [i·OUT_W +: OUT_W] of `ts_value`, and its stop vector occupies bits [i·N_TAP +: N_TAP] of `stop_phase`.
- R4: `ts_valid[i]` is high for exactly the one cycle after the edge that captured the stop. `ts_value` keeps its value until the next accepted stop on that channel.
- R5: While `cal_mode` is high, a `stop_hit[i]` stores the count of that channel's vector as P and marks the channel calibrated. A vector with count zero is ignored.
- R6: Until every channel has been calibrated, `start` is ignored and neither `ts_valid` nor `ts_ovf` rises.
- R7: All channels run against the same start and coarse count. Channels may stop in the same cycle with different P and Fp, and each one yields its own result.
- R8: After a channel has accepted a stop, further `stop_hit` pulses on it are ignored until the next start.
- R9: A stop is accepted for N from 1 to TMO_CYC−1. At the edge where N reaches TMO_CYC, every channel with no accepted stop pulses `ts_ovf` for one cycle, and a stop arriving at that edge is rejected.
- R10: A `stop_hit` sampled at the start capture edge, or while no measurement is open, is ignored.
- R11: A later calibration replaces P, and the results that follow use the new scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_mode | input | 1 | High: stop hits load the period per channel |
| start | input | 1 | Start event seen in this cycle |
| start_phase | input | N_TAP | Sampled delay-line vector of the start edge |
| stop_hit | input | N_CH | Stop event per channel in this cycle |
| stop_phase | input | N_CH·N_TAP | Sampled delay-line vectors of the stop edges |
| ts_value | output | N_CH·OUT_W | Scaled interval per channel |
| ts_valid | output | N_CH | One-cycle result strobe per channel |
| ts_ovf | output | N_CH | One-cycle timeout strobe per channel |

## Verification
The hardest case to reach is the edge at which the coarse counter hits its limit. At that edge one channel's stop must be rejected and turned into an overflow, while a stop on another channel one edge earlier is still accepted. The bench aligns stops to exact edge counts by driving on the falling edge, counting edges from the start. The bench also runs a near-exhaustive sweep over several calibrated periods, every start and stop fraction of an 8-tap line, and several coarse counts, up to one below the limit. It predicts each value from the formula in R3, and follows each accepted stop with a second hit that must leave the result untouched.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  // fractional bits of the stored per-channel reciprocal
  localparam int unsigned TDC_RB = 12;
endpackage

// File: rtl/tdc_therm2bin.sv
module tdc_therm2bin #(
  parameter int unsigned N_TAP = 32,
  localparam int unsigned FW   = $clog2(N_TAP + 1)
) (
  input  logic [N_TAP-1:0] vec,
  output logic [FW-1:0]    cnt
);
  // ones count: tolerant to bubbles, no transition search
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N_TAP; i++) begin
      cnt = cnt + FW'(vec[i]);
    end
  end
endmodule

// File: rtl/tdc_coarse.sv
module tdc_coarse #(
  parameter int unsigned N_TAP   = 32,
  parameter int unsigned TMO_CYC = 255,
  localparam int unsigned CNT_W  = $clog2(TMO_CYC + 1),
  localparam int unsigned FW     = $clog2(N_TAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_mode,
  input  logic             start_ok,
  input  logic [FW-1:0]    start_fine_in,
  output logic [CNT_W-1:0] cnt,
  output logic [FW-1:0]    start_fine,
  output logic             win,
  output logic             tmo
);
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FW-1:0]    sf_q, sf_d;
  logic             at_lim;

  assign at_lim = (cnt_q == CNT_W'(TMO_CYC));

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    sf_d    = sf_q;
    if (cal_mode) begin
      armed_d = 1'b0;
    end else if (start_ok) begin
      armed_d = 1'b1;
      cnt_d   = CNT_W'(1);
      sf_d    = start_fine_in;
    end else if (armed_q) begin
      if (at_lim) armed_d = 1'b0;
      else        cnt_d   = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sf_q    <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      sf_q    <= sf_d;
    end
  end

  assign cnt        = cnt_q;
  assign start_fine = sf_q;
  assign win        = armed_q & ~at_lim & ~start_ok & ~cal_mode;
  assign tmo        = armed_q &  at_lim & ~start_ok & ~cal_mode;

  // R9: an open measurement always has a count in 1..TMO_CYC
  p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q != '0) && (cnt_q <= CNT_W'(TMO_CYC)));
  // R9: reaching the limit closes the measurement
  p_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && at_lim && !start_ok && !cal_mode) |=> !armed_q);
endmodule

// File: rtl/tdc_channel.sv
module tdc_channel
  import tdc_pkg::*;
#(
  parameter int unsigned N_TAP       = 32,
  parameter int unsigned TMO_CYC     = 255,
  parameter int unsigned LSB_PER_CLK = 64,
  parameter int unsigned OUT_W       = 16,
  localparam int unsigned CNT_W      = $clog2(TMO_CYC + 1),
  localparam int unsigned FW         = $clog2(N_TAP + 1),
  localparam int unsigned IW         = CNT_W + FW + 1,
  localparam int unsigned RW         = $clog2(LSB_PER_CLK) + TDC_RB + 1,
  localparam int unsigned PW         = IW + RW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_mode,
  input  logic             all_cal,
  input  logic             meas_clr,
  input  logic             win,
  input  logic             tmo,
  input  logic [CNT_W-1:0] cnt,
  input  logic [FW-1:0]    start_fine,
  input  logic             hit,
  input  logic [N_TAP-1:0] phase,
  output logic [OUT_W-1:0] ts,
  output logic             vld,
  output logic             ovf,
  output logic             cal_ok
);
  localparam logic [RW-1:0] NUM = RW'(LSB_PER_CLK) << TDC_RB;

  logic [FW-1:0]    fine, per_q, per_d, div_in;
  logic [RW-1:0]    rcp_q, rcp_d;
  logic             cal_q, cal_d, got_q, got_d, vld_q, vld_d, ovf_q, ovf_d;
  logic [OUT_W-1:0] ts_q, ts_d;
  logic [IW-1:0]    ivl;
  logic [PW-1:0]    prod;
  logic             take, cal_take;

  tdc_therm2bin #(.N_TAP(N_TAP)) i_t2b (.vec(phase), .cnt(fine));

  assign take     = win & hit & ~got_q;
  assign cal_take = cal_mode & hit & (fine != '0);
  assign div_in   = (fine == '0) ? FW'(1) : fine;
  assign ivl      = IW'(cnt) * IW'(per_q) + IW'(start_fine) - IW'(fine);
  assign prod     = PW'(ivl) * PW'(rcp_q);

  always_comb begin
    per_d = per_q;
    rcp_d = rcp_q;
    cal_d = cal_q;
    if (cal_take) begin
      per_d = fine;
      rcp_d = NUM / RW'(div_in);
      cal_d = 1'b1;
    end
    got_d = meas_clr ? 1'b0 : (got_q | take);
    vld_d = take;
    ovf_d = tmo & ~got_q;
    ts_d  = take ? OUT_W'(prod >> TDC_RB) : ts_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      rcp_q <= '0;
      cal_q <= 1'b0;
      got_q <= 1'b0;
      vld_q <= 1'b0;
      ovf_q <= 1'b0;
      ts_q  <= '0;
    end else begin
      per_q <= per_d;
      rcp_q <= rcp_d;
      cal_q <= cal_d;
      got_q <= got_d;
      vld_q <= vld_d;
      ovf_q <= ovf_d;
      ts_q  <= ts_d;
    end
  end

  assign ts     = ts_q;
  assign vld    = vld_q;
  assign ovf    = ovf_q;
  assign cal_ok = cal_q;

  // R8: once a stop is held, no second strobe before a new start
  p_first_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (got_q && !meas_clr) |=> !vld_q);
  // R6: strobes only once the whole block is calibrated
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q || ovf_q) |-> $past(all_cal));
  // R9: a channel never reports a value and an overflow together
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_q && ovf_q));
  // R5: a nonzero calibration hit marks the channel calibrated
  p_cal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode && hit && (fine != '0)) |=> cal_q);
endmodule

// File: rtl/tdc_backend.sv
module tdc_backend #(
  parameter int unsigned N_CH        = 4,
  parameter int unsigned N_TAP       = 32,
  parameter int unsigned TMO_CYC     = 255,
  parameter int unsigned LSB_PER_CLK = 64,
  parameter int unsigned OUT_W       = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cal_mode,
  input  logic                    start,
  input  logic [N_TAP-1:0]        start_phase,
  input  logic [N_CH-1:0]         stop_hit,
  input  logic [N_CH*N_TAP-1:0]   stop_phase,
  output logic [N_CH*OUT_W-1:0]   ts_value,
  output logic [N_CH-1:0]         ts_valid,
  output logic [N_CH-1:0]         ts_ovf
);
  localparam int unsigned CNT_W = $clog2(TMO_CYC + 1);
  localparam int unsigned FW    = $clog2(N_TAP + 1);

  logic [N_CH-1:0]  cal_seen;
  logic             all_cal, start_ok, win, tmo;
  logic [FW-1:0]    sf_bin, sf_q;
  logic [CNT_W-1:0] cnt;

  assign all_cal  = &cal_seen;
  assign start_ok = start & ~cal_mode & all_cal;

  tdc_therm2bin #(.N_TAP(N_TAP)) i_start_t2b (.vec(start_phase), .cnt(sf_bin));

  tdc_coarse #(.N_TAP(N_TAP), .TMO_CYC(TMO_CYC)) i_coarse (
    .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .start_ok(start_ok),
    .start_fine_in(sf_bin), .cnt(cnt), .start_fine(sf_q), .win(win), .tmo(tmo)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tdc_channel #(
      .N_TAP(N_TAP), .TMO_CYC(TMO_CYC),
      .LSB_PER_CLK(LSB_PER_CLK), .OUT_W(OUT_W)
    ) i_ch (
      .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .all_cal(all_cal),
      .meas_clr(start_ok), .win(win), .tmo(tmo), .cnt(cnt),
      .start_fine(sf_q), .hit(stop_hit[g]),
      .phase(stop_phase[g*N_TAP +: N_TAP]),
      .ts(ts_value[g*OUT_W +: OUT_W]), .vld(ts_valid[g]),
      .ovf(ts_ovf[g]), .cal_ok(cal_seen[g])
    );
  end

  // R10: no result strobe in the cycle after a start capture edge
  p_start_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (ts_valid == '0));
endmodule

// File: tb/test_tdc_backend.sv
module test_tdc_backend;
  localparam int NC = 3, TP = 8, TMO = 10, K = 64, OW = 16;
  localparam time PER = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, cal_mode = 1'b0, start = 1'b0;
  logic [TP-1:0]    start_phase = '0;
  logic [NC-1:0]    stop_hit = '0;
  logic [NC*TP-1:0] stop_phase = '0;
  logic [NC*OW-1:0] ts_value;
  logic [NC-1:0]    ts_valid, ts_ovf;

  int total = 0, bad = 0, per[NC];
  bit fin = 0;

  always #(PER/2) clk = ~clk;

  tdc_backend #(.N_CH(NC), .N_TAP(TP), .TMO_CYC(TMO), .LSB_PER_CLK(K), .OUT_W(OW))
    i_tdc_backend (.clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .start(start),
      .start_phase(start_phase), .stop_hit(stop_hit), .stop_phase(stop_phase),
      .ts_value(ts_value), .ts_valid(ts_valid), .ts_ovf(ts_ovf));

  function automatic logic [TP-1:0] therm(int k);
    return (k >= TP) ? {TP{1'b1}} : TP'((1 << k) - 1);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cal(input logic [TP-1:0] v [NC]);
    @(negedge clk);
    cal_mode = 1'b1; stop_hit = '1;
    for (int i = 0; i < NC; i++) stop_phase[i*TP +: TP] = v[i];
    @(negedge clk);
    stop_hit = '0; cal_mode = 1'b0;
    for (int i = 0; i < NC; i++) if ($countones(v[i]) != 0) per[i] = $countones(v[i]);
  endtask

  // start with vector sv, all channels stop N edges later; second hit follows
  task automatic meas(input int n, input logic [TP-1:0] sv, input logic [TP-1:0] tv [NC]);
    longint e [NC];
    for (int i = 0; i < NC; i++) begin
      longint iv = longint'(n) * per[i] + $countones(sv) - $countones(tv[i]);
      e[i] = ((iv * ((K * 4096) / per[i])) >> 12) & 16'hFFFF;
    end
    @(negedge clk); start = 1'b1; start_phase = sv;
    @(negedge clk); start = 1'b0;
    repeat (n - 1) @(negedge clk);
    stop_hit = '1;
    for (int i = 0; i < NC; i++) stop_phase[i*TP +: TP] = tv[i];
    @(negedge clk);
    chk(ts_valid == '1, "R4 valid after stop", ts_valid, 7);
    for (int i = 0; i < NC; i++) chk(ts_value[i*OW +: OW] == e[i], "R3/R7 value", ts_value[i*OW +: OW], e[i]);
    stop_phase = '1;   // second hit, different vector
    @(negedge clk);
    stop_hit = '0;
    chk(ts_valid == '0, "R4/R8 single strobe, second hit ignored", ts_valid, 0);
    @(negedge clk);
    chk(ts_valid == '0, "R8 second hit no strobe", ts_valid, 0);
    for (int i = 0; i < NC; i++) chk(ts_value[i*OW +: OW] == e[i], "R8 value held", ts_value[i*OW +: OW], e[i]);
  endtask

  initial begin
    #(PER * 150000);
    if (!fin) begin
      fin = 1; total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [TP-1:0] v [NC];
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ts_valid == '0, "R1 valid", ts_valid, 0);
    chk(ts_ovf == '0, "R1 ovf", ts_ovf, 0);
    chk(ts_value == '0, "R1 value", ts_value, 0);
    rst_n = 1'b1;

    // R6: uncalibrated, start and stops ignored; R5 zero vector ignored
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin
        v[0] = '0; v[1] = therm(4); v[2] = therm(4);
        do_cal(v);
      end
      @(negedge clk); start = 1'b1; start_phase = therm(2);
      @(negedge clk); start = 1'b0; stop_hit = '1; stop_phase = '1;
      @(negedge clk); stop_hit = '0;
      for (int c = 0; c < TMO + 3; c++) begin
        chk(ts_valid == '0 && ts_ovf == '0, pass ? "R5 zero cal ignored" : "R6 gated",
            {ts_valid, ts_ovf}, 0);
        @(negedge clk);
      end
    end

    // R2: bubbled vectors (8'b0101_1011 -> 5, 8'b0000_1101 -> 3)
    v[0] = 8'b0101_1011; v[1] = therm(7); v[2] = therm(6);
    do_cal(v);
    chk(per[0] == 5, "R2 bubble count", per[0], 5);
    v[0] = 8'b0000_1101; v[1] = 8'b0010_0101; v[2] = therm(1);
    meas(3, 8'b0001_0110, v);

    // R10: hit at start edge ignored, then normal hit at N=2
    v[0] = therm(8); v[1] = therm(7); v[2] = therm(6);
    do_cal(v);
    @(negedge clk); start = 1'b1; start_phase = therm(4); stop_hit = '1; stop_phase = '0;
    @(negedge clk); start = 1'b0; stop_hit = '0;
    chk(ts_valid == '0, "R10 hit at start edge", ts_valid, 0);
    @(negedge clk); stop_hit = 3'b001; stop_phase[0 +: TP] = therm(3);
    @(negedge clk); stop_hit = '0;
    chk(ts_valid == 3'b001, "R10 later hit accepted", ts_valid, 1);
    chk(ts_value[0 +: OW] == 16'((((2*8 + 4 - 3) * (K*4096/8)) >> 12)), "R10 value",
        ts_value[0 +: OW], ((2*8 + 4 - 3) * (K*4096/8)) >> 12);

    // R9: ch0 at TMO-1 accepted, ch1 none, ch2 at TMO rejected
    @(negedge clk); start = 1'b1; start_phase = therm(2);
    @(negedge clk); start = 1'b0;
    repeat (TMO - 2) @(negedge clk);
    stop_hit = 3'b001; stop_phase = '0; stop_phase[0 +: TP] = therm(5);
    @(negedge clk);
    chk(ts_valid == 3'b001 && ts_ovf == '0, "R9 last window edge", {ts_valid, ts_ovf}, 8);
    chk(ts_value[0 +: OW] == 16'((((TMO-1)*8 + 2 - 5) * (K*4096/8)) >> 12), "R9 value",
        ts_value[0 +: OW], (((TMO-1)*8 + 2 - 5) * (K*4096/8)) >> 12);
    stop_hit = 3'b100; stop_phase[2*TP +: TP] = therm(1);
    @(negedge clk); stop_hit = '0;
    chk(ts_ovf == 3'b110, "R9 overflow", ts_ovf, 6);
    chk(ts_valid == '0, "R9 hit at limit rejected", ts_valid, 0);
    @(negedge clk);
    chk(ts_ovf == '0, "R9 overflow pulse", ts_ovf, 0);
    // R10: idle hit ignored
    stop_hit = '1;
    @(negedge clk); stop_hit = '0;
    chk(ts_valid == '0 && ts_ovf == '0, "R10 idle hit", {ts_valid, ts_ovf}, 0);

    // R3/R7/R11: sweep over periods, counts and fractions
    for (int pc = 5; pc <= 8; pc++) begin
      for (int i = 0; i < NC; i++) v[i] = therm(pc - i);
      do_cal(v);
      chk(per[2] == pc - 2, "R11 recal", per[2], pc - 2);
      foreach (v[i]) v[i] = '0;
      for (int ni = 0; ni < 4; ni++) begin
        int n = (ni == 3) ? TMO - 1 : ni + 1;
        for (int sf = 0; sf <= TP; sf++) begin
          for (int tf = 0; tf <= TP; tf++) begin
            for (int i = 0; i < NC; i++) v[i] = therm(tf % (per[i] + 1));
            meas(n, therm(sf), v);
          end
        end
      end
    end

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule